// File: doc/BRIEF.md
# Event Flag Combiner with Dual Masking

The block collects single-cycle event pulses from up to 128 sources and records each one in a sticky flag. The flags are organised as four groups of 32. Event number `e` lands in group `e / 32`, bit `e % 32`. A flag stays set until software clears it. Software can also raise flags directly, which is useful for test or software-generated events.

Each group carries two independent masks over the same flags.

- **Interrupt mask.** It yields a masked view per group and one combined interrupt line per group.
- **Exception mask.** It yields a second masked view per group. All groups feed one shared exception line.

For both masks a mask bit of 1 blocks the flag and a 0 lets it through.

All registers are reached over a simple synchronous register bus. It has a write strobe with address and data, and a read strobe whose data appears one cycle later. An address is the concatenation `{kind[2:0], group[1:0]}`. The kind codes are:

| Kind | Register | Access |
|------|----------|--------|
| 0 | raw flags | read-only |
| 1 | set | write-one-to-set |
| 2 | clear | write-one-to-clear |
| 3 | interrupt mask | read/write |
| 4 | interrupt masked view | read-only |
| 5 | exception mask | read/write |
| 6 | exception masked view | read-only |
| 7 | reserved | read-only |

Top module: `evtcomb_top`

## Requirements
- R1: A one-cycle high pulse on `evt_in[g*32+b]` sets flag bit `b` of group `g` at the next clock edge. The flag stays set through later cycles with no event and no write.
- R2: A write to kind 1 (set) of group `g` sets every flag bit of that group whose data bit is 1 and leaves the others unchanged.
- R3: A write to kind 2 (clear) of group `g` clears exactly the flag bits whose data bit is 1. A clear word of zero changes nothing.
- R4: The interrupt mask (kind 3) is read/write. The interrupt masked view (kind 4) equals flags AND NOT mask, so a mask bit of 1 blocks that flag.
- R5: `grp_irq[g]` is high exactly when the interrupt masked view of group `g` is nonzero.
- R6: The exception mask (kind 5) is read/write. The exception masked view (kind 6) equals flags AND NOT exception mask. `exc_irq` is high exactly when any group's exception masked view is nonzero.
- R7: After reset, all flags are 0 and every bit of both masks is 1, so `grp_irq` and `exc_irq` are low.
- R8: When an event pulse and a clear write hit the same flag bit in the same cycle, the flag ends up set.
- R9: `rd_data` shows the addressed register one cycle after a read strobe. The set, clear and reserved kinds read as zero. Writes to the read-only kinds (0, 4, 6, 7) change no state.
- R10: Writing one mask leaves the other mask of the same group unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 128 | Event pulses, bit g*32+b goes to group g bit b |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address {kind, group} |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Read address {kind, group} |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| grp_irq | output | 4 | Per-group combined interrupt |
| exc_irq | output | 1 | Combined exception across all groups |

## Verification
The assertions assume that `evt_in` and the register strobes are free of unknowns while reset is released. They also assume that at most one register access of each direction happens per cycle, so a set and a clear never reach the same group in one cycle.

The stimulus drives every input a moment after the rising edge. It holds event, write and read strobes high for exactly one cycle and returns them to zero in between. As a result, only the deliberate event-plus-clear collision puts two flag updates in the same cycle.

// File: rtl/evtcomb_pkg.sv
package evtcomb_pkg;
   localparam int KIND_W = 3;

   typedef enum logic [KIND_W-1:0] {
      K_FLAG  = 3'd0,
      K_SET   = 3'd1,
      K_CLR   = 3'd2,
      K_IMASK = 3'd3,
      K_IVIEW = 3'd4,
      K_XMASK = 3'd5,
      K_XVIEW = 3'd6,
      K_RSVD  = 3'd7
   } reg_kind_e;
endpackage

// File: rtl/evtcomb_group.sv
module evtcomb_group #(
   parameter int GROUP_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [GROUP_W-1:0] evt,
   input  logic [GROUP_W-1:0] wdata,
   input  logic               wr_set,
   input  logic               wr_clr,
   input  logic               wr_imask,
   input  logic               wr_xmask,
   output logic [GROUP_W-1:0] flags,
   output logic [GROUP_W-1:0] imask,
   output logic [GROUP_W-1:0] xmask,
   output logic [GROUP_W-1:0] ivw,
   output logic [GROUP_W-1:0] xvw,
   output logic               irq,
   output logic               xany
);
   logic [GROUP_W-1:0] set_vec, clr_vec;

   always_comb begin
      set_vec = wr_set ? wdata : '0;
      clr_vec = wr_clr ? wdata : '0;
   end

   // Clear is applied first, then set and events OR in: a colliding event survives.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         imask <= '1;
         xmask <= '1;
      end else begin
         flags <= (flags & ~clr_vec) | set_vec | evt;
         if (wr_imask) imask <= wdata;
         if (wr_xmask) xmask <= wdata;
      end
   end

   always_comb begin
      ivw  = flags & ~imask;
      xvw  = flags & ~xmask;
      irq  = |ivw;
      xany = |xvw;
   end

   assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_set && !wr_clr && evt == '0) |=> (flags == $past(flags)));

   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));

   assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((flags & $past(wdata) & ~$past(evt)) == '0));

   assert_mask_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_imask && !wr_xmask) |=> (imask == $past(wdata) && xmask == $past(xmask)));
endmodule

// File: rtl/evtcomb_rdmux.sv
module evtcomb_rdmux
   import evtcomb_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   parameter int GROUP_W    = 32,
   localparam int GRP_W     = $clog2(NUM_GROUPS),
   localparam int TOT_W     = NUM_GROUPS * GROUP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_en,
   input  reg_kind_e          rd_kind,
   input  logic [GRP_W-1:0]   rd_grp,
   input  logic [TOT_W-1:0]   flags_all,
   input  logic [TOT_W-1:0]   imask_all,
   input  logic [TOT_W-1:0]   ivw_all,
   input  logic [TOT_W-1:0]   xmask_all,
   input  logic [TOT_W-1:0]   xvw_all,
   output logic [GROUP_W-1:0] rd_data
);
   logic [GROUP_W-1:0] sel;
   int unsigned        base;

   always_comb begin
      base = 32'(rd_grp) * GROUP_W;
      unique case (rd_kind)
         K_FLAG:  sel = flags_all[base +: GROUP_W];
         K_IMASK: sel = imask_all[base +: GROUP_W];
         K_IVIEW: sel = ivw_all[base +: GROUP_W];
         K_XMASK: sel = xmask_all[base +: GROUP_W];
         K_XVIEW: sel = xvw_all[base +: GROUP_W];
         default: sel = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= sel;
   end

   assert_wo_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (rd_kind == K_SET || rd_kind == K_CLR || rd_kind == K_RSVD))
      |=> (rd_data == '0));
endmodule

// File: rtl/evtcomb_top.sv
module evtcomb_top
   import evtcomb_pkg::*;
#(
   parameter int NUM_GROUPS = 4,
   parameter int GROUP_W    = 32,
   localparam int GRP_W     = $clog2(NUM_GROUPS),
   localparam int ADDR_W    = KIND_W + GRP_W,
   localparam int TOT_W     = NUM_GROUPS * GROUP_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [TOT_W-1:0]      evt_in,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [GROUP_W-1:0]    wr_data,
   input  logic                  rd_en,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic [GROUP_W-1:0]    rd_data,
   output logic [NUM_GROUPS-1:0] grp_irq,
   output logic                  exc_irq
);
   if (NUM_GROUPS < 2 || (NUM_GROUPS & (NUM_GROUPS - 1)) != 0) begin : g_bad_groups
      $error("NUM_GROUPS must be a power of two, at least 2");
   end
   if (GROUP_W < 1) begin : g_bad_width
      $error("GROUP_W must be positive");
   end

   reg_kind_e        wr_kind, rd_kind;
   logic [GRP_W-1:0] wr_grp, rd_grp;

   always_comb begin
      wr_kind = reg_kind_e'(wr_addr[ADDR_W-1 -: KIND_W]);
      wr_grp  = wr_addr[GRP_W-1:0];
      rd_kind = reg_kind_e'(rd_addr[ADDR_W-1 -: KIND_W]);
      rd_grp  = rd_addr[GRP_W-1:0];
   end

   logic [TOT_W-1:0]      flags_all, imask_all, xmask_all, ivw_all, xvw_all;
   logic [NUM_GROUPS-1:0] xany;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic hit;
      assign hit = wr_en && (wr_grp == GRP_W'(g));

      evtcomb_group #(.GROUP_W(GROUP_W)) u_grp (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt      (evt_in[g*GROUP_W +: GROUP_W]),
         .wdata    (wr_data),
         .wr_set   (hit && wr_kind == K_SET),
         .wr_clr   (hit && wr_kind == K_CLR),
         .wr_imask (hit && wr_kind == K_IMASK),
         .wr_xmask (hit && wr_kind == K_XMASK),
         .flags    (flags_all[g*GROUP_W +: GROUP_W]),
         .imask    (imask_all[g*GROUP_W +: GROUP_W]),
         .xmask    (xmask_all[g*GROUP_W +: GROUP_W]),
         .ivw      (ivw_all[g*GROUP_W +: GROUP_W]),
         .xvw      (xvw_all[g*GROUP_W +: GROUP_W]),
         .irq      (grp_irq[g]),
         .xany     (xany[g])
      );
   end

   assign exc_irq = |xany;

   evtcomb_rdmux #(.NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .rd_kind   (rd_kind),
      .rd_grp    (rd_grp),
      .flags_all (flags_all),
      .imask_all (imask_all),
      .ivw_all   (ivw_all),
      .xmask_all (xmask_all),
      .xvw_all   (xvw_all),
      .rd_data   (rd_data)
   );
endmodule

// File: tb/sim_evtcomb_top.sv
`timescale 1ns/1ps
module sim_evtcomb_top;
   logic         clk = 1'b0;
   logic         rst_n;
   logic [127:0] evt_in;
   logic         wr_en, rd_en;
   logic [4:0]   wr_addr, rd_addr;
   logic [31:0]  wr_data, rd_data;
   logic [3:0]   grp_irq;
   logic         exc_irq;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   evtcomb_top u0 (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .grp_irq(grp_irq), .exc_irq(exc_irq)
   );

   // Bench model of the state
   logic [31:0] mf[4], mi[4], mx[4];

   logic [31:0] exp_q[$];
   string       tag_q[$];

   function automatic logic [31:0] model_rd(int k, int g);
      case (k)
         0: return mf[g];
         3: return mi[g];
         4: return mf[g] & ~mi[g];
         5: return mx[g];
         6: return mf[g] & ~mx[g];
         default: return 32'h0;
      endcase
   endfunction

   task automatic step(input logic [127:0] ev, input bit we, input int k,
                       input int g, input logic [31:0] d);
      @(posedge clk); #1;
      evt_in  = ev;
      wr_en   = we;
      wr_addr = {k[2:0], g[1:0]};
      wr_data = d;
      if (we) begin
         case (k)
            1: mf[g] = mf[g] | d;
            2: mf[g] = mf[g] & ~d;
            3: mi[g] = d;
            5: mx[g] = d;
            default: ;
         endcase
      end
      for (int i = 0; i < 4; i++) mf[i] = mf[i] | ev[i*32 +: 32];
      @(posedge clk); #1;
      evt_in = '0;
      wr_en  = 1'b0;
   endtask

   task automatic rd(input int k, input int g, input string tag);
      @(posedge clk); #1;
      rd_en   = 1'b1;
      rd_addr = {k[2:0], g[1:0]};
      exp_q.push_back(model_rd(k, g));
      tag_q.push_back(tag);
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   task automatic chk_out(input string tag);
      logic [3:0] ei;
      logic       ex;
      @(negedge clk);
      ex = 1'b0;
      for (int i = 0; i < 4; i++) begin
         ei[i] = |(mf[i] & ~mi[i]);
         ex    = ex | (|(mf[i] & ~mx[i]));
      end
      checks++;
      if (grp_irq !== ei || exc_irq !== ex) begin
         errors++;
         $display("FAIL %s: grp_irq=%b exc_irq=%b expected grp_irq=%b exc_irq=%b",
                  tag, grp_irq, exc_irq, ei, ex);
      end
   endtask

   // Monitor: compares read data one cycle after each read strobe
   bit rd_pend = 1'b0;
   always @(negedge clk) begin
      if (rd_pend) begin
         logic [31:0] e;
         string       t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (rd_data !== e) begin
            errors++;
            $display("FAIL %s: rd_data=%h expected %h", t, rd_data, e);
         end
      end
      rd_pend = rd_en;
   end

   initial begin
      #(5.0 * 200000);
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [127:0] ev;
      rst_n = 1'b0; evt_in = '0; wr_en = 0; rd_en = 0;
      wr_addr = '0; rd_addr = '0; wr_data = '0;
      for (int i = 0; i < 4; i++) begin mf[i] = '0; mi[i] = '1; mx[i] = '1; end
      repeat (3) @(posedge clk);
      chk_out("R7 outputs in reset");
      #1 rst_n = 1'b1;

      // R7 reset values
      for (int g = 0; g < 4; g++) begin
         rd(3, g, "R7 imask reset");
         rd(5, g, "R7 xmask reset");
         rd(0, g, "R7 flags reset");
      end

      // R1 events at 0, 37, 127; masked so no irq (R4)
      ev = '0; ev[0] = 1'b1; ev[37] = 1'b1; ev[127] = 1'b1;
      step(ev, 0, 0, 0, 0);
      repeat (4) @(posedge clk);
      rd(0, 0, "R1 flag g0 sticky");
      rd(0, 1, "R1 flag g1 bit5");
      rd(0, 3, "R1 flag g3 bit31");
      chk_out("R4 all masked no irq");

      // R4/R5 unmask g1 bit5
      step('0, 1, 3, 1, ~32'h20);
      chk_out("R5 irq g1 after unmask");
      rd(4, 1, "R4 ivview g1");
      rd(3, 1, "R4 imask g1");
      rd(5, 1, "R10 xmask g1 untouched");

      // R2 write-one-to-set
      step('0, 1, 1, 2, 32'h0000_00F0);
      rd(0, 2, "R2 set g2");
      // R3 write-one-to-clear
      step('0, 1, 2, 2, 32'h0000_0030);
      rd(0, 2, "R3 clear g2 partial");
      step('0, 1, 2, 2, 32'h0);
      rd(0, 2, "R3 zero clear no effect");
      step('0, 1, 3, 2, 32'h0);
      chk_out("R5 irq g1 and g2");

      // R6 exception mask
      step('0, 1, 5, 3, 32'h7FFF_FFFF);
      chk_out("R6 exc_irq from g3");
      rd(6, 3, "R6 xview g3");
      rd(3, 3, "R10 imask g3 untouched");

      // R8 event and clear collide
      ev = '0; ev[4] = 1'b1;
      step(ev, 1, 2, 0, 32'h0000_0011);
      rd(0, 0, "R8 set wins over clear");

      // R9 writes to read-only kinds ignored; write-only kinds read zero
      step('0, 1, 0, 0, 32'hFFFF_FFFF);
      step('0, 1, 4, 1, 32'hFFFF_FFFF);
      step('0, 1, 6, 3, 32'h0);
      step('0, 1, 7, 2, 32'hFFFF_FFFF);
      rd(0, 0, "R9 flag write ignored");
      rd(4, 1, "R9 ivview write ignored");
      rd(6, 3, "R9 xview write ignored");
      rd(1, 2, "R9 set reads zero");
      rd(2, 2, "R9 clear reads zero");
      rd(7, 0, "R9 reserved reads zero");
      chk_out("R9 outputs unchanged");

      // R6 clear exception source
      step('0, 1, 2, 3, 32'hFFFF_FFFF);
      chk_out("R6 exc_irq drops after clear");
      rd(6, 3, "R6 xview g3 empty");

      repeat (3) @(posedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule